// File: doc/BRIEF.md
# Per-CPU Interrupt Mailbox

This block gives every CPU in a cluster one interrupt mailbox. An external interrupt source offers requests, each naming a target CPU, a 5-bit source ID and two 64-bit data words. A mailbox holds one request at a time. While it is occupied, its busy flag is set and further requests to that CPU are refused, so the sender must offer them again later. When a request is taken, the source and both data words are stored, the busy flag is raised, and an interrupt is posted to the target CPU with a single shared vector that software programs.

Software reaches the mailboxes through a simple register port. Three indexed arrays hold the first data words, the second data words and the busy/source words. A fourth region holds alias addresses that resolve to the mailbox of the CPU making the access, together with the shared vector register. A mailbox is released only when software writes its busy flag back to zero.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset every busy flag, source ID, data word and the shared vector read as zero, no interrupt is posted, and a request to any CPU is accepted.
- R2: A request whose target CPU has its busy flag set is refused in the same cycle (`req_accept` low). It posts no interrupt and leaves that mailbox's stored source and data unchanged.
- R3: A request whose target is free is accepted combinationally in the cycle `req_valid` is high. From the next cycle on, the busy flag is set and the source ID and both data words of that request read back.
- R4: One cycle after an acceptance, `post_valid` is high for exactly one cycle, with `post_cpu` set to the target and `post_vec` set to the shared vector as it stood in the accepting cycle. Without an acceptance, `post_valid` stays low.
- R5: The shared vector is written through the alias region, select 3. It loads write-data bits 5:0 and ignores the other bits. A read returns the vector in bits 5:0 and zero above them.
- R6: A busy word reads with the busy flag in bit 5, the source ID in bits 4:0, and zero in all other bits.
- R7: A write to a busy word loads the busy flag from write-data bit 5 and leaves the stored source ID unchanged. Writing 0 frees the mailbox, so the next request to that CPU is accepted. Writing 1 marks it busy, so requests are refused.
- R8: The register address is decoded as follows. Bits [SEL_W+4:SEL_W+3] choose the region: 0 is the first data words, 1 is the second data words, 2 is the busy words, 3 is the alias region. Bits [SEL_W+2:3] carry the select, and the CPU index is the byte offset within a region shifted right by 3. Bits 2:0 are ignored.
- R9: In the alias region, select 0, 1 and 2 access the first data word, the second data word and the busy word of the mailbox numbered by `reg_cpu`, for both reads and busy writes.
- R10: If a busy write of 0 and a request hit the same CPU in the same cycle, the clear takes effect first and the request is accepted.
- R11: The data words are read-only from the register port: writes to regions 0 and 1, and to alias selects 0 and 1, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming mailbox request present |
| req_cpu | input | IDX_W | Target CPU of the request |
| req_src | input | 5 | Source ID of the request |
| req_d0 | input | 64 | First data word |
| req_d1 | input | 64 | Second data word |
| req_accept | output | 1 | Request taken this cycle (combinational) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_cpu | input | IDX_W | ID of the CPU making the register access |
| reg_rdata | output | 64 | Register read data (combinational) |
| post_valid | output | 1 | Interrupt post pulse |
| post_cpu | output | IDX_W | CPU receiving the interrupt |
| post_vec | output | 6 | Vector delivered with the interrupt |

## Verification
The bench builds the block with NUM_CPU = 4, which gives a 2-bit select and a 7-bit address. This size lets every mailbox run through the full sequence: accept, post, refuse while busy, set busy by software and clear it. Each mailbox is reached both by its index and through the alias with a matching requester ID. Expected register words and addresses are worked out arithmetically from the region/select layout. With only four slots, the same-cycle clear-and-request race and the ignored-bit cases can be placed on particular CPUs without a long run.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int SRC_W    = 5;
  localparam int VEC_W    = 6;
  localparam int DATA_W   = 64;
  localparam int BUSY_BIT = 5;
  localparam int WORD_SH  = 3;
  localparam int REGION_W = 2;

  typedef enum logic [2:0] {K_NONE, K_D0, K_D1, K_BUSY, K_VEC} kind_e;
  typedef enum logic [1:0] {RG_D0 = 2'd0, RG_D1 = 2'd1, RG_BUSY = 2'd2, RG_ALIAS = 2'd3} region_e;

  // busy word layout: flag in bit 5, source in the low bits
  function automatic logic [DATA_W-1:0] pack_busy(input logic busy, input logic [SRC_W-1:0] src);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SRC_W-1:0] = src;
    w[BUSY_BIT]  = busy;
    return w;
  endfunction

  // which register kind a region/alias select pair names
  function automatic kind_e region_kind(input region_e rg, input logic [1:0] sub);
    kind_e k;
    case (rg)
      RG_D0:   k = K_D0;
      RG_D1:   k = K_D1;
      RG_BUSY: k = K_BUSY;
      default: begin
        case (sub)
          2'd0:    k = K_D0;
          2'd1:    k = K_D1;
          2'd2:    k = K_BUSY;
          default: k = K_VEC;
        endcase
      end
    endcase
    return k;
  endfunction
endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 32,
  parameter int IDX_W   = 5,
  parameter int SEL_W   = 5,
  parameter int ADDR_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  cpu,
  output kind_e             kind,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  logic [SEL_W-1:0] sel;
  region_e          rg;
  logic             alias_ok;
  logic             idx_ok;
  logic             unused_low;

  assign sel        = addr[WORD_SH +: SEL_W];
  assign rg         = region_e'(addr[WORD_SH+SEL_W +: REGION_W]);
  assign unused_low = ^addr[WORD_SH-1:0];
  assign alias_ok   = (sel >> 2) == '0;

  always_comb begin
    kind   = region_kind(rg, sel[1:0]);
    idx    = sel[IDX_W-1:0];
    idx_ok = 32'(sel) < NUM_CPU;
    if (rg == RG_ALIAS) begin
      idx    = cpu;
      idx_ok = 32'(cpu) < NUM_CPU;
      if (!alias_ok) kind = K_NONE;
    end
    hit = (kind == K_VEC) || ((kind != K_NONE) && idx_ok);
  end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic              sw_busy,
  input  logic              acc,
  input  logic [SRC_W-1:0]  src,
  input  logic [DATA_W-1:0] d0,
  input  logic [DATA_W-1:0] d1,
  output logic              busy,
  output logic [SRC_W-1:0]  src_q,
  output logic [DATA_W-1:0] d0_q,
  output logic [DATA_W-1:0] d1_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      src_q <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
    end else begin
      if (sw_we) busy <= sw_busy;
      if (acc) begin
        busy  <= 1'b1;
        src_q <= src;
        d0_q  <= d0;
        d1_q  <= d1;
      end
    end
  end

  // R3: acceptance latches everything and marks busy
  a_r3_latch: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy && src_q == $past(src) && d0_q == $past(d0) && d1_q == $past(d1));
  // R2: a busy slot without a software write is never overwritten
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sw_we |=> busy && $stable(src_q) && $stable(d0_q) && $stable(d1_q));
  // R7: software clear frees the slot
  a_r7_free: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we && !sw_busy && !acc |=> !busy && $stable(src_q));
endmodule

// File: rtl/mbx_post.sv
module mbx_post
  import mbx_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [IDX_W-1:0] cpu,
  input  logic [VEC_W-1:0] vec,
  output logic             post_valid,
  output logic [IDX_W-1:0] post_cpu,
  output logic [VEC_W-1:0] post_vec
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
    end else begin
      post_valid <= acc;
      if (acc) begin
        post_cpu <= cpu;
        post_vec <= vec;
      end
    end
  end

  // R4: one post per acceptance, carrying target and vector
  a_r4_post: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> post_valid && post_cpu == $past(cpu) && post_vec == $past(vec));
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !post_valid);
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
  import mbx_pkg::*;
#(
  parameter  int NUM_CPU = 32,
  localparam int IDX_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int SEL_W   = (IDX_W < 2) ? 2 : IDX_W,
  localparam int ADDR_W  = REGION_W + SEL_W + WORD_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_cpu,
  input  logic [4:0]        req_src,
  input  logic [63:0]       req_d0,
  input  logic [63:0]       req_d1,
  output logic              req_accept,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  input  logic [IDX_W-1:0]  reg_cpu,
  output logic [63:0]       reg_rdata,
  output logic              post_valid,
  output logic [IDX_W-1:0]  post_cpu,
  output logic [5:0]        post_vec
);
  kind_e             dec_kind;
  logic [IDX_W-1:0]  dec_idx;
  logic              dec_hit;
  logic              busy_we;
  logic              vec_we;
  logic [VEC_W-1:0]  vec_q;
  logic [NUM_CPU-1:0] busy_v;
  logic [NUM_CPU-1:0] clr_v;
  logic [NUM_CPU-1:0] acc_v;
  logic [SRC_W-1:0]  src_a [NUM_CPU];
  logic [DATA_W-1:0] d0_a  [NUM_CPU];
  logic [DATA_W-1:0] d1_a  [NUM_CPU];
  logic              tgt_ok;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:VEC_W];

  mbx_addr_dec #(
    .NUM_CPU(NUM_CPU), .IDX_W(IDX_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(reg_addr), .cpu(reg_cpu), .kind(dec_kind), .idx(dec_idx), .hit(dec_hit)
  );

  assign busy_we = reg_we && dec_hit && (dec_kind == K_BUSY);
  assign vec_we  = reg_we && dec_hit && (dec_kind == K_VEC);
  assign tgt_ok  = 32'(req_cpu) < NUM_CPU;

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT_ID = IDX_W'(i);
    logic sw_hit;
    assign sw_hit   = busy_we && (dec_idx == SLOT_ID);
    assign clr_v[i] = sw_hit && !reg_wdata[BUSY_BIT];
    // the clear is applied before the busy test
    assign acc_v[i] = req_valid && (req_cpu == SLOT_ID) && (!busy_v[i] || clr_v[i]);

    mbx_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .sw_we(sw_hit), .sw_busy(reg_wdata[BUSY_BIT]),
      .acc(acc_v[i]), .src(req_src), .d0(req_d0), .d1(req_d1),
      .busy(busy_v[i]), .src_q(src_a[i]), .d0_q(d0_a[i]), .d1_q(d1_a[i])
    );
  end

  assign req_accept = |acc_v;

  always_ff @(posedge clk) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_we) vec_q <= reg_wdata[VEC_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (dec_hit) begin
      case (dec_kind)
        K_D0:    reg_rdata = d0_a[dec_idx];
        K_D1:    reg_rdata = d1_a[dec_idx];
        K_BUSY:  reg_rdata = pack_busy(busy_v[dec_idx], src_a[dec_idx]);
        K_VEC:   reg_rdata = {{(DATA_W-VEC_W){1'b0}}, vec_q};
        default: reg_rdata = '0;
      endcase
    end
  end

  mbx_post #(.IDX_W(IDX_W)) u_post (
    .clk(clk), .rst_n(rst_n), .acc(req_accept), .cpu(req_cpu), .vec(vec_q),
    .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
  );

  // R3: at most one mailbox takes a request per cycle
  a_r3_single: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(acc_v));
  // R2: busy target without a same-cycle clear refuses
  a_r2_reject: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && tgt_ok && busy_v[req_cpu] && !clr_v[req_cpu] |-> !req_accept);
  // R10: clear and request together: request wins
  a_r10_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && tgt_ok && clr_v[req_cpu] |-> req_accept);
  // R5: vector register takes the low write-data bits
  a_r5_vec: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |=> vec_q == $past(reg_wdata[VEC_W-1:0]));
  // R1: accepted requests always name an existing CPU
  a_r1_target: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |-> tgt_ok);
endmodule

// File: tb/mbx_mailbox_tb.sv
`timescale 1ns/100ps
module mbx_mailbox_tb;
  localparam int NC = 4;
  localparam int IW = 2;
  localparam int SW = 2;
  localparam int AW = 2 + SW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [IW-1:0] req_cpu = '0;
  logic [4:0] req_src = '0;
  logic [63:0] req_d0 = '0, req_d1 = '0;
  logic req_accept;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [IW-1:0] reg_cpu = '0;
  logic [63:0] reg_rdata;
  logic post_valid;
  logic [IW-1:0] post_cpu;
  logic [5:0] post_vec;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbx_mailbox #(.NUM_CPU(NC)) u_dut (
    .clk, .rst_n, .req_valid, .req_cpu, .req_src, .req_d0, .req_d1, .req_accept,
    .reg_we, .reg_addr, .reg_wdata, .reg_cpu, .reg_rdata,
    .post_valid, .post_cpu, .post_vec
  );

  function automatic logic [AW-1:0] ad(input int rg, input int sel);
    return AW'((rg << (SW + 3)) | (sel << 3));
  endfunction
  function automatic logic [63:0] bw(input logic b, input logic [4:0] s);
    return (64'(b) << 5) | 64'(s);
  endfunction
  function automatic logic [63:0] pat0(input int c, input int k);
    return 64'hA5C3_0000_0000_0000 ^ (64'(c) << 40) ^ (64'(k) * 64'h0101_0101);
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input int cpu, output logic [63:0] v);
    reg_addr = a; reg_cpu = IW'(cpu);
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input int cpu, input logic [63:0] d);
    reg_we = 1'b1; reg_addr = a; reg_cpu = IW'(cpu); reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  // drive a request for one cycle; returns accept and the post seen next
  task automatic send(input int c, input logic [4:0] s, input logic [63:0] a, input logic [63:0] b,
                      output logic acc, output logic pv, output logic [IW-1:0] pc, output logic [5:0] pvec);
    req_valid = 1'b1; req_cpu = IW'(c); req_src = s; req_d0 = a; req_d1 = b;
    #1 acc = req_accept;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    #1 pv = post_valid; pc = post_cpu; pvec = post_vec;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic acc, pv;
    logic [IW-1:0] pc;
    logic [5:0] pvec;
    logic [5:0] vec;
    logic [4:0] src [NC];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 post", 64'(post_valid), 64'd0);
    for (int c = 0; c < NC; c++) begin
      rd(ad(2, c), 0, v); chk("R1 busy", v, 64'd0);
      rd(ad(0, c), 0, v); chk("R1 d0", v, 64'd0);
      rd(ad(1, c), 0, v); chk("R1 d1", v, 64'd0);
    end
    rd(ad(3, 3), 0, v); chk("R1 vec", v, 64'd0);

    // R5: vector write keeps bits 5:0 only
    vec = 6'h2A;
    wr(ad(3, 3), 0, 64'hFFFF_FFFF_FFFF_FFC0 | 64'(vec));
    rd(ad(3, 3), 1, v); chk("R5 vec", v, 64'(vec));

    for (int c = 0; c < NC; c++) begin
      src[c] = 5'((c * 7 + 3) & 31);
      // R3 accept, R4 post
      send(c, src[c], pat0(c, 1), ~pat0(c, 1), acc, pv, pc, pvec);
      chk("R3 accept", 64'(acc), 64'd1);
      chk("R4 post_valid", 64'(pv), 64'd1);
      chk("R4 post_cpu", 64'(pc), 64'(c));
      chk("R4 post_vec", 64'(pvec), 64'(vec));
      @(negedge clk);
      chk("R4 single pulse", 64'(post_valid), 64'd0);
      // R8 indexed reads (low bits ignored), R6 busy format
      rd(ad(0, c) | AW'(5), 0, v); chk("R8 d0", v, pat0(c, 1));
      rd(ad(1, c), 0, v); chk("R8 d1", v, ~pat0(c, 1));
      rd(ad(2, c), 0, v); chk("R6 busy word", v, bw(1'b1, src[c]));
      // R9 alias reads
      rd(ad(3, 0), c, v); chk("R9 alias d0", v, pat0(c, 1));
      rd(ad(3, 1), c, v); chk("R9 alias d1", v, ~pat0(c, 1));
      rd(ad(3, 2), c, v); chk("R9 alias busy", v, bw(1'b1, src[c]));
      // R2 refusal while busy
      send(c, 5'd31, pat0(c, 9), pat0(c, 8), acc, pv, pc, pvec);
      chk("R2 refuse", 64'(acc), 64'd0);
      chk("R2 no post", 64'(pv), 64'd0);
      rd(ad(0, c), 0, v); chk("R2 d0 kept", v, pat0(c, 1));
      rd(ad(2, c), 0, v); chk("R2 src kept", v, bw(1'b1, src[c]));
      // R11 data words read-only
      wr(ad(0, c), 0, 64'd0);
      wr(ad(3, 1), c, 64'd0);
      rd(ad(0, c), 0, v); chk("R11 d0 ro", v, pat0(c, 1));
      rd(ad(1, c), 0, v); chk("R11 d1 ro", v, ~pat0(c, 1));
      // R7 clear (indexed for even, alias for odd), other bits set
      if (c % 2 == 0) wr(ad(2, c), 0, 64'hFFFF_FFFF_FFFF_FFDF);
      else            wr(ad(3, 2), c, 64'hFFFF_FFFF_FFFF_FFDF);
      rd(ad(2, c), 0, v); chk("R7 cleared", v, bw(1'b0, src[c]));
      // R7 set by software, then refused, then cleared
      wr(ad(2, c), 0, 64'h20);
      rd(ad(2, c), 0, v); chk("R7 set", v, bw(1'b1, src[c]));
      send(c, 5'd1, 64'd0, 64'd0, acc, pv, pc, pvec);
      chk("R7 set refuses", 64'(acc), 64'd0);
      wr(ad(2, c), 0, 64'h0);
    end

    // R10: same-cycle clear and request on CPU 2
    send(2, 5'd9, pat0(2, 4), pat0(2, 5), acc, pv, pc, pvec);
    chk("R10 pre accept", 64'(acc), 64'd1);
    vec = 6'h15;
    wr(ad(3, 3), 0, 64'(vec));
    reg_we = 1'b1; reg_addr = ad(2, 2); reg_wdata = 64'd0; reg_cpu = '0;
    send(2, 5'd17, pat0(2, 6), pat0(2, 7), acc, pv, pc, pvec);
    reg_we = 1'b0;
    chk("R10 accept", 64'(acc), 64'd1);
    chk("R10 post_vec", 64'(pvec), 64'(vec));
    rd(ad(2, 2), 0, v); chk("R10 busy", v, bw(1'b1, 5'd17));
    rd(ad(0, 2), 0, v); chk("R10 d0", v, pat0(2, 6));
    // neighbour untouched
    rd(ad(2, 3), 0, v); chk("R2 neighbour", v, bw(1'b0, src[3]));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule